// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This controller-side block keeps a two-bank SDR SDRAM refreshed and steers it in and out of its low-power self-refresh state. An interval timer raises a refresh obligation every `REF_INTERVAL` clocks; obligations that cannot be served at once are counted, up to `MAX_PEND`. For each obligation the block raises `ref_req` to the main command arbiter. The arbiter closes the banks and then answers with `arb_gnt` together with `bank_idle`. Only then does the block put an auto-refresh command on the pins. It then holds the command bus in DESELECT for the guard window.

A level request `pwr_save_req` makes the block run a burst of `BURST_LEN` auto-refreshes. It then issues the self-refresh entry command with CKE low and keeps CKE low for as long as the request stays high. When the request falls, CKE rises in a DESELECT cycle. A row-cycle guard follows, and then a second refresh burst before the bus is handed back. The block has no data path, so every pin is a plain level. `ref_req` stays high from the request until the sequence ends, and the arbiter must not drive commands while `busy` is high.

Top module: `sdram_refresh_seq`

## Requirements
- R1: Out of reset, and whenever the block is idle, the pins carry DESELECT with the clock enabled. That is cke=1, cs_n=1, ras_n=1, cas_n=1, we_n=1, with ref_req=0 and busy=0.
- R2: A refresh obligation is created every REF_INTERVAL clocks. After reset, ref_req first rises REF_INTERVAL+1 clocks after the first rising edge.
- R3: The auto-refresh command is cke=1, cs_n=0, ras_n=0, cas_n=0, we_n=1. It appears only after arb_gnt and bank_idle were both sampled high in the waiting state, and only when cke was high in the previous cycle.
- R4: After every auto-refresh, at least max(T_RC, T_RP) DESELECT cycles follow before the block drives any other command.
- R5: Obligations that arise while the grant is withheld are counted up to MAX_PEND, and further ones are dropped. Once the grant arrives, exactly one auto-refresh is issued per counted obligation.
- R6: When pwr_save_req rises and BURST_EN is set, BURST_LEN auto-refreshes are issued first. They are followed by the self-refresh entry command: cke=0, cs_n=0, ras_n=0, cas_n=0, we_n=1.
- R7: While in self-refresh, cke stays 0 and cs_n stays 1, whatever arb_gnt and bank_idle do.
- R8: One cycle after pwr_save_req falls, cke returns to 1 in a DESELECT cycle. At least T_RC further DESELECT cycles follow before any command.
- R9: After the exit guard, BURST_LEN auto-refreshes are issued, then ref_req falls.
- R10: busy is high from the first command cycle until the last guard window ends, is never high without ref_req, and is low in the idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; must keep running through self-refresh |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_idle | input | 1 | Arbiter reports both banks precharged |
| arb_gnt | input | 1 | Arbiter hands the command bus to this block |
| pwr_save_req | input | 1 | Level request to stay in self-refresh |
| ref_req | output | 1 | Asks the arbiter to close banks and yield the bus |
| busy | output | 1 | Block owns the command bus |
| cke | output | 1 | Clock enable pin |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |

## Verification
The bench holds the grant back while the banks are busy, and then while only the banks are still open. A sequencer that refreshed on either signal alone would put a refresh on the pins too early. It stretches the grant delay across several intervals and past the saturation limit. A wrong pending counter would give too few refreshes or an unbounded catch-up burst. Around self-refresh it toggles grant and bank status while CKE is low, and it measures the DESELECT gap after the exit edge. A design that skipped the exit guard, or that left self-refresh on the same edge as the request falls, would show up as a short gap or a missing DESELECT on the rising CKE.

// File: rtl/refseq_pkg.sv
package refseq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_AREF, ST_GUARD, ST_SRE, ST_SRH, ST_SRX
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_NORM, PH_PRE, PH_EXIT, PH_POST
  } seq_phase_e;

  typedef struct packed {
    logic cke;
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pin_cmd_t;

  localparam pin_cmd_t PIN_DESEL = '{cke: 1'b1, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam pin_cmd_t PIN_AREF  = '{cke: 1'b1, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam pin_cmd_t PIN_SRE   = '{cke: 1'b0, cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
  localparam pin_cmd_t PIN_SRH   = '{cke: 1'b0, cs_n: 1'b1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int unsigned REF_INTERVAL = 3120,
  parameter int unsigned MAX_PEND     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic consume,
  output logic has_pending
);
  localparam int unsigned CW = $clog2(REF_INTERVAL);
  localparam int unsigned PW = $clog2(MAX_PEND + 1);
  localparam logic [CW-1:0] T_LAST = CW'(REF_INTERVAL - 1);
  localparam logic [PW-1:0] P_MAX  = PW'(MAX_PEND);

  logic [CW-1:0] tcnt;
  logic [PW-1:0] pend;
  logic          tick, up, dn;

  assign tick = (tcnt == T_LAST);
  assign up   = tick && (pend != P_MAX);
  assign dn   = consume && (pend != '0);
  assign has_pending = (pend != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tick ? '0 : tcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear)  pend <= '0;
    else if (tick && dn)  pend <= pend;
    else if (up)          pend <= pend + 1'b1;
    else if (dn)          pend <= pend - 1'b1;
  end

  // R5: a tick that finds room is never lost
  a_r5_tick_counted: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clear && !consume) |=> has_pending);
endmodule

// File: rtl/guard_timer.sv
module guard_timer #(
  parameter int unsigned MAXV = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [$clog2(MAXV+1)-1:0]    load_val,
  output logic                         expired
);
  localparam int unsigned W = $clog2(MAXV + 1);
  logic [W-1:0] cnt;

  assign expired = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (load)     cnt <= load_val;
    else if (!expired) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq
  import refseq_pkg::*;
#(
  parameter int unsigned REF_INTERVAL = 3120,
  parameter int unsigned T_RC         = 14,
  parameter int unsigned T_RP         = 4,
  parameter int unsigned BURST_LEN    = 8,
  parameter int unsigned MAX_PEND     = 8,
  parameter bit          BURST_EN     = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bank_idle,
  input  logic arb_gnt,
  input  logic pwr_save_req,
  output logic ref_req,
  output logic busy,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n
);
  localparam int unsigned GAP = (T_RC > T_RP) ? T_RC : T_RP;
  localparam int unsigned GW  = $clog2(GAP + 1);
  localparam int unsigned BW  = $clog2(BURST_LEN + 1);
  localparam int unsigned XW  = $clog2(T_RC + 1);
  localparam logic [GW-1:0] LD_AREF = GW'(GAP - 1);
  localparam logic [GW-1:0] LD_EXIT = GW'(T_RC - 1);
  localparam logic [BW-1:0] B_LEN   = BURST_EN ? BW'(BURST_LEN) : '0;

  seq_state_e state;
  seq_phase_e phase;
  logic [BW-1:0] bcnt;
  logic          cke_q, has_pending, g_exp, g_load, go;
  logic [GW-1:0] g_val;
  pin_cmd_t      pins;

  refresh_timer #(.REF_INTERVAL(REF_INTERVAL), .MAX_PEND(MAX_PEND)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .clear(state == ST_SRX), .consume(state == ST_AREF),
    .has_pending(has_pending)
  );

  assign g_load = (state == ST_AREF) || (state == ST_SRX);
  assign g_val  = (state == ST_SRX) ? LD_EXIT : LD_AREF;

  guard_timer #(.MAXV(GAP)) u_guard (
    .clk(clk), .rst_n(rst_n), .load(g_load), .load_val(g_val), .expired(g_exp)
  );

  assign go = arb_gnt && bank_idle && cke_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      phase <= PH_NORM;
      bcnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (pwr_save_req) begin
            state <= ST_WAIT;
            phase <= PH_PRE;
            bcnt  <= B_LEN;
          end else if (has_pending) begin
            state <= ST_WAIT;
            phase <= PH_NORM;
          end
        end
        ST_WAIT: begin
          if (go) state <= (phase == PH_PRE && bcnt == '0) ? ST_SRE : ST_AREF;
        end
        ST_AREF: begin
          state <= ST_GUARD;
          if (bcnt != '0) bcnt <= bcnt - 1'b1;
        end
        ST_GUARD: begin
          if (g_exp) begin
            unique case (phase)
              PH_NORM: state <= ST_IDLE;
              PH_PRE:  state <= (bcnt == '0) ? ST_SRE : ST_AREF;
              PH_EXIT: begin
                if (B_LEN != '0) begin
                  state <= ST_AREF;
                  phase <= PH_POST;
                  bcnt  <= B_LEN;
                end else begin
                  state <= ST_IDLE;
                  phase <= PH_NORM;
                end
              end
              PH_POST: begin
                if (bcnt == '0) begin
                  state <= ST_IDLE;
                  phase <= PH_NORM;
                end else begin
                  state <= ST_AREF;
                end
              end
              default: state <= ST_IDLE;
            endcase
          end
        end
        ST_SRE: state <= ST_SRH;
        ST_SRH: if (!pwr_save_req) state <= ST_SRX;
        ST_SRX: begin
          state <= ST_GUARD;
          phase <= PH_EXIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_AREF: pins = PIN_AREF;
      ST_SRE:  pins = PIN_SRE;
      ST_SRH:  pins = PIN_SRH;
      default: pins = PIN_DESEL;
    endcase
  end

  assign cke   = pins.cke;
  assign cs_n  = pins.cs_n;
  assign ras_n = pins.ras_n;
  assign cas_n = pins.cas_n;
  assign we_n  = pins.we_n;

  assign ref_req = (state != ST_IDLE);
  assign busy    = (state != ST_IDLE) && (state != ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end

  // window counters for the guard checks
  logic          aref_pin;
  logic [GW-1:0] since_aref;
  logic [XW-1:0] since_exit;
  assign aref_pin = cke && !cs_n && !ras_n && !cas_n && we_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_aref <= GW'(GAP);
      since_exit <= XW'(T_RC);
    end else begin
      if (aref_pin)                    since_aref <= '0;
      else if (since_aref != GW'(GAP)) since_aref <= since_aref + 1'b1;
      if (state == ST_SRX)              since_exit <= '0;
      else if (since_exit != XW'(T_RC)) since_exit <= since_exit + 1'b1;
    end
  end

  // R3: refresh only with the clock enabled in the previous cycle
  a_r3_cke_prev: assert property (@(posedge clk) disable iff (!rst_n)
    aref_pin |-> $past(cke));
  // R3: no refresh right after a waiting cycle without grant and idle banks
  a_r3_need_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WAIT && !(arb_gnt && bank_idle)) |=> !aref_pin);
  // R4: full guard window between refreshes
  a_r4_gap: assert property (@(posedge clk) disable iff (!rst_n)
    aref_pin |-> (since_aref == GW'(GAP)));
  // R7: only DESELECT while the clock enable stays low
  a_r7_sr_desel: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke && $past(!cke)) |-> cs_n);
  // R8: exit edge carries DESELECT and the exit guard is honoured
  a_r8_exit_desel: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> cs_n);
  a_r8_exit_gap: assert property (@(posedge clk) disable iff (!rst_n)
    aref_pin |-> (since_exit == XW'(T_RC)));
  // R10: bus ownership implies an open request
  a_r10_busy_req: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ref_req);
endmodule

// File: tb/sim_sdram_refresh_seq.sv
`timescale 1ns/1ps
module sim_sdram_refresh_seq;
  localparam int REF_INTERVAL = 100;
  localparam int T_RC = 6;
  localparam int T_RP = 3;
  localparam int BURST_LEN = 3;
  localparam int MAX_PEND = 4;
  localparam int GAP = (T_RC > T_RP) ? T_RC : T_RP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bank_idle = 1'b1, arb_gnt = 1'b0, pwr_save_req = 1'b0;
  logic ref_req, busy, cke, cs_n, ras_n, cas_n, we_n;

  always #2.5 clk = ~clk;

  sdram_refresh_seq #(
    .REF_INTERVAL(REF_INTERVAL), .T_RC(T_RC), .T_RP(T_RP),
    .BURST_LEN(BURST_LEN), .MAX_PEND(MAX_PEND), .BURST_EN(1'b1)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .bank_idle(bank_idle), .arb_gnt(arb_gnt),
    .pwr_save_req(pwr_save_req), .ref_req(ref_req), .busy(busy),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n)
  );

  int n_tests = 0, n_fail = 0;
  int aref_cnt = 0, sre_cnt = 0;
  int nogrant_viol = 0, gap_viol = 0, exit_viol = 0;
  int since_a = 1000, since_x = 1000;
  logic prev_cke = 1'b1;

  function automatic logic is_aref();
    return cke && !cs_n && !ras_n && !cas_n && we_n;
  endfunction
  function automatic logic is_sre();
    return !cke && !cs_n && !ras_n && !cas_n && we_n;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // pin monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (is_aref()) begin
        aref_cnt++;
        if (!(arb_gnt && bank_idle)) nogrant_viol++;
        if (since_a < GAP) gap_viol++;
        if (since_x < T_RC) exit_viol++;
        since_a = 0;
      end else begin
        since_a++;
      end
      if (is_sre()) sre_cnt++;
      if (cke && !prev_cke) since_x = 0;
      else since_x++;
      prev_cke = cke;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    step(5);
    @(negedge clk);
    chk(cke && cs_n && ras_n && cas_n && we_n, "R1 reset pins",
        {cke, cs_n, ras_n, cas_n, we_n}, 5'b11111);
    chk(!ref_req && !busy, "R1 reset handshake", {ref_req, busy}, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
  endtask

  task automatic t_periodic();
    int n = 0;
    int base;
    while (!ref_req && n < 300) begin
      @(negedge clk);
      n++;
    end
    chk(n >= 100 && n <= 104, "R2 first request time", n, 102);
    chk(!busy, "R10 busy low while waiting", busy, 0);
    base = aref_cnt;
    step(20);
    chk(aref_cnt == base, "R3 no refresh without grant", aref_cnt - base, 0);
    bank_idle = 1'b0;
    arb_gnt = 1'b1;
    step(10);
    chk(aref_cnt == base, "R3 no refresh with banks open", aref_cnt - base, 0);
    bank_idle = 1'b1;
    n = 0;
    while (!is_aref() && n < 6) begin
      @(negedge clk);
      n++;
    end
    chk(is_aref(), "R3 refresh after grant", aref_cnt - base, 1);
    begin
      int bad = 0;
      for (int i = 0; i < GAP; i++) begin
        @(negedge clk);
        if (!cs_n || !busy) bad++;
      end
      chk(bad == 0, "R4 deselect guard with busy", bad, 0);
    end
    @(negedge clk);
    chk(!busy && !ref_req, "R10 release after guard", {busy, ref_req}, 0);
    chk(cke && cs_n, "R1 idle pins", {cke, cs_n}, 2'b11);
    step(1);
    arb_gnt = 1'b0;
  endtask

  task automatic t_postpone(input int extra_ticks, input int expect_n, input string tag);
    int n = 0;
    int base;
    while (!ref_req && n < 400) begin
      @(negedge clk);
      n++;
    end
    step(extra_ticks * REF_INTERVAL + 10);
    base = aref_cnt;
    arb_gnt = 1'b1;
    step(60);
    chk(aref_cnt - base == expect_n, tag, aref_cnt - base, expect_n);
    chk(gap_viol == 0, "R4 spacing in catch-up", gap_viol, 0);
    arb_gnt = 1'b0;
  endtask

  task automatic t_selfref();
    int n = 0;
    int base, bad;
    arb_gnt = 1'b1;
    bank_idle = 1'b1;
    while (!ref_req && n < 400) begin @(negedge clk); n++; end
    n = 0;
    while (ref_req && n < 100) begin @(negedge clk); n++; end
    step(2);
    base = aref_cnt;
    pwr_save_req = 1'b1;
    n = 0;
    while (!is_sre() && n < 100) begin @(negedge clk); n++; end
    chk(is_sre(), "R6 entry command", sre_cnt, 1);
    chk(aref_cnt - base == BURST_LEN, "R6 pre-entry burst", aref_cnt - base, BURST_LEN);
    step(1);
    arb_gnt = 1'b0;
    bank_idle = 1'b0;
    bad = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (cke || !cs_n) bad++;
      if (i == 40) arb_gnt = 1'b1;
      if (i == 80) bank_idle = 1'b1;
      if (i == 100) arb_gnt = 1'b0;
    end
    chk(bad == 0, "R7 clock enable held low", bad, 0);
    chk(busy, "R10 busy in self-refresh", busy, 1);
    arb_gnt = 1'b1;
    bank_idle = 1'b1;
    step(1);
    pwr_save_req = 1'b0;
    @(negedge clk);
    chk(!cke, "R8 no exit on request edge", cke, 0);
    @(negedge clk);
    chk(cke && cs_n, "R8 exit with deselect", {cke, cs_n}, 2'b11);
    bad = 0;
    for (int i = 0; i < T_RC; i++) begin
      @(negedge clk);
      if (!cs_n) bad++;
    end
    chk(bad == 0, "R8 exit guard", bad, 0);
    base = aref_cnt;
    n = 0;
    while (ref_req && n < 100) begin @(negedge clk); n++; end
    chk(aref_cnt - base == BURST_LEN, "R9 post-exit burst", aref_cnt - base, BURST_LEN);
    chk(!ref_req && !busy, "R9 request dropped", {ref_req, busy}, 0);
    chk(exit_viol == 0, "R8 exit spacing", exit_viol, 0);
    chk(nogrant_viol == 0, "R3 refresh only under grant", nogrant_viol, 0);
  endtask

  initial begin
    t_reset();
    t_periodic();
    t_postpone(2, 3, "R5 postponed refreshes");
    t_postpone(5, MAX_PEND, "R5 saturated count");
    t_selfref();
    chk(gap_viol == 0, "R4 overall spacing", gap_viol, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule